// File: doc/BRIEF.md
# Block Security Map Register Bank

This block is the software-visible configuration side of a block-granular memory security filter. Memory behind the filter is cut into equal blocks. Each block has one bit in a table of 32-bit words. A bit value of 1 marks the block non-secure and a bit value of 0 marks it secure. Software reaches the table indirectly: it loads a word pointer and then reads or writes a data window. The pointer can step forward by itself after each full-word window access, so a whole table can be streamed without reloading the pointer.

The bank also holds a control word, with an error-response select, an auto-step select and a one-way lock. It holds interrupt status with its enable, set and clear controls, and two fault-information words. The information words are filled through a dedicated capture port. A read-only identification area sits near the top of the 4 KB window. Non-secure bus requesters see only that identification area. Every other location reads zero for them, and their writes are dropped. The filter datapath gets a separate table read port, plus the control bits and the interrupt enable.

The bus is a simple single-cycle register port. Read data is combinational from the current state. Writes and read side effects take effect at the clock edge that ends the access. A narrow access carries its data in the low bits of the data buses and names its byte offset in the two low address bits. A halfword access is treated as aligned to bit 1 of the address.

Top module: `secmap_cfg`

## Requirements
- R1: After reset the register values are: control word 0x00000100, interrupt enable 1, word pointer 0, interrupt status 0, both fault words 0, and every table word 0. The interrupt output is low.
- R2: The control word at offset 0x00 keeps only three bits: bit 4 (error response), bit 8 (auto-step) and bit 31 (lock). All other bits read 0 and ignore writes. The three bits drive the outputs errRespEn, autoIncEn and lockdown.
- R3: A non-secure access (busSecure=0) to any offset below 0xFD0 reads 0 and changes no state. The identification area answers accesses of either security state.
- R4: Offset 0x10 reads LUT_WORDS-1. Offset 0x14 reads log2(BLOCK_BYTES)-5.
- R5: The data window at offset 0x1C reads and writes table[pointer]. When auto-step is set, a full-word window access moves the pointer to (pointer+1) modulo LUT_WORDS after the access. Byte and halfword window accesses never move the pointer.
- R6: A write to the pointer at offset 0x18 stores the written value modulo LUT_WORDS.
- R7: While lock is set, writes to the control word, the data window and the interrupt enable are ignored. Only reset clears lock. Pointer writes and interrupt set/clear still work while locked.
- R8: Size encoding is busSize 0 = byte, 1 = halfword, 2 = word. A narrow write to the control word, the pointer or the data window merges into the current contents. A narrow write to any other register zero-fills the remaining bytes. A narrow read returns the addressed lanes right-justified.
- R9: Writing bit 0 = 1 to offset 0x34 sets the interrupt status. Writing bit 0 = 1 to offset 0x24 clears it. Both offsets read 0. Offset 0x20 reads the status in bit 0. Offset 0x28 holds the enable in bit 0. irqOut is high exactly when status and enable are both 1.
- R10: A pulse on faultWe sets the interrupt status. The same pulse loads offset 0x2C with faultAddr and offset 0x30 with {faultCfgNs at bit 17, faultNonSec at bit 16, faultMaster in bits 15:0}. When faultWe and a status clear fall in the same cycle, the status ends up set.
- R11: Offsets 0xFD0 to 0xFFC, one word each, read the bytes 04, 00, 00, 00, 60, B8, 1B, 00, 0D, F0, 05, B1 in bits 7:0.
- R12: The output lutRdWord equals table[lutRdIdx] at all times.
- R13: Reads of undefined offsets return 0. Writes to undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSecure | input | 1 | Security state of the access, 1 = secure |
| busAddr | input | 12 | Byte offset within the 4 KB window |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word |
| busWdata | input | 32 | Write data, narrow data in the low bits |
| busRdata | output | 32 | Read data, narrow data in the low bits |
| lutRdIdx | input | IDXW | Filter-side table word select |
| lutRdWord | output | 32 | Filter-side table word |
| errRespEn | output | 1 | Control bit 4 |
| autoIncEn | output | 1 | Control bit 8 |
| lockdown | output | 1 | Control bit 31 |
| irqEn | output | 1 | Interrupt enable |
| irqOut | output | 1 | Interrupt request |
| faultWe | input | 1 | Fault capture strobe |
| faultAddr | input | 32 | Captured fault address |
| faultMaster | input | 16 | Captured requester id |
| faultNonSec | input | 1 | Captured non-secure flag |
| faultCfgNs | input | 1 | Captured table bit for the faulting block |

## Verification
Two situations are hard to reach from the ports. The first is a pointer that wraps during a streamed table write. The bench reaches it by filling every table word with auto-step on and then writing once more: the extra write must land in word 0 and leave the pointer at 1. The second is a fault capture in the same cycle as a software status clear. A dedicated task raises faultWe in the same cycle as a write to the clear offset, and then confirms that the status stays set. Lock is tested last, and reset is the only way out of it, so the bench pulses reset and checks that the control word and the table have returned to their reset values.

// File: rtl/secmap_pkg.sv
package secmap_pkg;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_NWRD  = 12'h010;
  localparam logic [11:0] OFS_GRAN  = 12'h014;
  localparam logic [11:0] OFS_PTR   = 12'h018;
  localparam logic [11:0] OFS_WIN   = 12'h01C;
  localparam logic [11:0] OFS_STAT  = 12'h020;
  localparam logic [11:0] OFS_CLR   = 12'h024;
  localparam logic [11:0] OFS_EN    = 12'h028;
  localparam logic [11:0] OFS_FADDR = 12'h02C;
  localparam logic [11:0] OFS_FINFO = 12'h030;
  localparam logic [11:0] OFS_SET   = 12'h034;
  localparam logic [11:0] OFS_IDLO  = 12'hFD0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_NWRD, SEL_GRAN, SEL_PTR, SEL_WIN,
    SEL_STAT, SEL_EN, SEL_FADDR, SEL_FINFO, SEL_ID
  } regSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrPtr;
    logic wrWin;
    logic wrEn;
    logic setStat;
    logic clrStat;
    logic advPtr;
  } cfgStrobe_t;

  function automatic logic [7:0] idByte(input logic [3:0] n);
    case (n)
      4'd0:    idByte = 8'h04;
      4'd4:    idByte = 8'h60;
      4'd5:    idByte = 8'hB8;
      4'd6:    idByte = 8'h1B;
      4'd8:    idByte = 8'h0D;
      4'd9:    idByte = 8'hF0;
      4'd10:   idByte = 8'h05;
      4'd11:   idByte = 8'hB1;
      default: idByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/secmap_ctrl.sv
module secmap_ctrl
  import secmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic             busSecure,
  input  logic [11:0]      busAddr,
  input  logic [1:0]       busSize,
  input  logic [31:0]      busWdata,
  input  logic             lockNow,
  input  logic             autoIncNow,
  output cfgStrobe_t       stb,
  output regSel_e          regSel,
  output logic [3:0]       idNum,
  output logic [31:0]      laneMask,
  output logic [4:0]       laneShift,
  output logic [31:0]      wrAligned
);

  logic [11:0] wordOfs;
  logic        nsBlocked;
  logic        accOk;
  logic        isWord;
  logic [31:0] baseMask;
  regSel_e     decSel;
  logic [11:0] idOfs;

  assign wordOfs   = {busAddr[11:2], 2'b00};
  assign nsBlocked = !busSecure && (wordOfs < OFS_IDLO);
  assign accOk     = busSel && !nsBlocked;
  assign isWord    = !(busSize == SZ_BYTE || busSize == SZ_HALF);
  assign idOfs     = wordOfs - OFS_IDLO;
  assign idNum     = idOfs[5:2];

  always_comb begin
    case (busSize)
      SZ_BYTE: begin baseMask = 32'h0000_00FF; laneShift = {busAddr[1:0], 3'b000}; end
      SZ_HALF: begin baseMask = 32'h0000_FFFF; laneShift = {busAddr[1], 4'b0000}; end
      default: begin baseMask = 32'hFFFF_FFFF; laneShift = 5'd0; end
    endcase
  end

  assign laneMask  = baseMask << laneShift;
  assign wrAligned = busWdata << laneShift;

  always_comb begin
    decSel = SEL_NONE;
    if (wordOfs >= OFS_IDLO) decSel = SEL_ID;
    else begin
      case (wordOfs)
        OFS_CTRL:  decSel = SEL_CTRL;
        OFS_NWRD:  decSel = SEL_NWRD;
        OFS_GRAN:  decSel = SEL_GRAN;
        OFS_PTR:   decSel = SEL_PTR;
        OFS_WIN:   decSel = SEL_WIN;
        OFS_STAT:  decSel = SEL_STAT;
        OFS_EN:    decSel = SEL_EN;
        OFS_FADDR: decSel = SEL_FADDR;
        OFS_FINFO: decSel = SEL_FINFO;
        default:   decSel = SEL_NONE;
      endcase
    end
  end

  assign regSel = (accOk && !busWrite) ? decSel : SEL_NONE;

  always_comb begin
    logic wr;
    logic bit0;
    wr   = accOk && busWrite;
    bit0 = (wrAligned[0] && laneMask[0]);
    stb  = '0;
    stb.wrCtrl  = wr && (wordOfs == OFS_CTRL) && !lockNow;
    stb.wrPtr   = wr && (wordOfs == OFS_PTR);
    stb.wrWin   = wr && (wordOfs == OFS_WIN) && !lockNow;
    stb.wrEn    = wr && (wordOfs == OFS_EN) && !lockNow;
    stb.setStat = wr && (wordOfs == OFS_SET) && bit0;
    stb.clrStat = wr && (wordOfs == OFS_CLR) && bit0;
    stb.advPtr  = accOk && (wordOfs == OFS_WIN) && isWord && autoIncNow &&
                  (!busWrite || !lockNow);
  end

  // R5: the pointer only steps on full-word accesses
  assert_step_word_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.advPtr |-> (busSize == SZ_WORD || busSize == 2'd3));

  // R7: no locked register is written while lock is set
  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockNow |-> !(stb.wrCtrl || stb.wrWin || stb.wrEn));

endmodule

// File: rtl/secmap_dp.sv
module secmap_dp
  import secmap_pkg::*;
#(
  parameter int LUT_WORDS   = 4,
  parameter int BLOCK_BYTES = 256,
  localparam int IDXW       = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       stb,
  input  regSel_e          regSel,
  input  logic [3:0]       idNum,
  input  logic [31:0]      laneMask,
  input  logic [4:0]       laneShift,
  input  logic [31:0]      wrAligned,
  input  logic             faultWe,
  input  logic [31:0]      faultAddr,
  input  logic [15:0]      faultMaster,
  input  logic             faultNonSec,
  input  logic             faultCfgNs,
  input  logic [IDXW-1:0]  lutRdIdx,
  output logic [31:0]      rdData,
  output logic [31:0]      lutRdWord,
  output logic             errResp,
  output logic             autoInc,
  output logic             lock,
  output logic             intEn,
  output logic             intStat
);

  localparam int GRAN_CODE = $clog2(BLOCK_BYTES) - 5;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LUT_WORDS - 1);

  logic [31:0]     lutMem [LUT_WORDS];
  logic [IDXW-1:0] ptr;
  logic [31:0]     faultAddrReg;
  logic [17:0]     faultInfoReg;
  logic [31:0]     ctrlWord;
  logic [31:0]     curWin;
  logic [31:0]     ctrlMerged;
  logic [31:0]     ptrMerged;
  logic [31:0]     ptrMod;
  logic [31:0]     winMerged;
  logic [31:0]     zeroFilled;
  logic [31:0]     regWord;

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [31:0] mask);
    mergeLanes = (oldVal & ~mask) | (newVal & mask);
  endfunction

  assign ctrlWord   = {lock, 22'b0, autoInc, 3'b0, errResp, 4'b0};
  assign curWin     = lutMem[ptr];
  assign ctrlMerged = mergeLanes(ctrlWord, wrAligned, laneMask);
  assign ptrMerged  = mergeLanes(32'(ptr), wrAligned, laneMask);
  assign ptrMod     = ptrMerged % 32'(LUT_WORDS);
  assign winMerged  = mergeLanes(curWin, wrAligned, laneMask);
  assign zeroFilled = wrAligned & laneMask;
  assign lutRdWord  = (32'(lutRdIdx) < 32'(LUT_WORDS)) ? lutMem[lutRdIdx] : 32'h0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errResp <= 1'b0;
      autoInc <= 1'b1;
      lock    <= 1'b0;
    end else if (stb.wrCtrl) begin
      errResp <= ctrlMerged[4];
      autoInc <= ctrlMerged[8];
      lock    <= ctrlMerged[31];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (stb.wrPtr)   ptr <= ptrMod[IDXW-1:0];
    else if (stb.advPtr)  ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
  end

  for (genvar w = 0; w < LUT_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     lutMem[w] <= '0;
      else if (stb.wrWin && ptr == IDXW'(w))         lutMem[w] <= winMerged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat      <= 1'b0;
      intEn        <= 1'b1;
      faultAddrReg <= '0;
      faultInfoReg <= '0;
    end else begin
      if (stb.wrEn) intEn <= zeroFilled[0];
      if (faultWe) begin
        intStat      <= 1'b1;
        faultAddrReg <= faultAddr;
        faultInfoReg <= {faultCfgNs, faultNonSec, faultMaster};
      end else if (stb.setStat) intStat <= 1'b1;
      else if (stb.clrStat)     intStat <= 1'b0;
    end
  end

  always_comb begin
    case (regSel)
      SEL_CTRL:  regWord = ctrlWord;
      SEL_NWRD:  regWord = 32'(LUT_WORDS - 1);
      SEL_GRAN:  regWord = 32'(GRAN_CODE);
      SEL_PTR:   regWord = 32'(ptr);
      SEL_WIN:   regWord = curWin;
      SEL_STAT:  regWord = {31'b0, intStat};
      SEL_EN:    regWord = {31'b0, intEn};
      SEL_FADDR: regWord = faultAddrReg;
      SEL_FINFO: regWord = {14'b0, faultInfoReg};
      SEL_ID:    regWord = {24'b0, idByte(idNum)};
      default:   regWord = 32'h0;
    endcase
  end

  assign rdData = (regWord & laneMask) >> laneShift;

  // R6: the pointer never leaves the table
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    32'(ptr) < 32'(LUT_WORDS));

  // R7: lock stays set until reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    lock |=> lock);

  // R7: locked control word and enable hold their values
  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    lock |=> ($stable(ctrlWord) && $stable(intEn)));

  // R10: a capture always leaves status set
  assert_fault_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultWe |=> intStat);

endmodule

// File: rtl/secmap_cfg.sv
module secmap_cfg
  import secmap_pkg::*;
#(
  parameter int LUT_WORDS   = 4,
  parameter int BLOCK_BYTES = 256,
  localparam int IDXW       = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic             busSecure,
  input  logic [11:0]      busAddr,
  input  logic [1:0]       busSize,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [IDXW-1:0]  lutRdIdx,
  output logic [31:0]      lutRdWord,
  output logic             errRespEn,
  output logic             autoIncEn,
  output logic             lockdown,
  output logic             irqEn,
  output logic             irqOut,
  input  logic             faultWe,
  input  logic [31:0]      faultAddr,
  input  logic [15:0]      faultMaster,
  input  logic             faultNonSec,
  input  logic             faultCfgNs
);

  cfgStrobe_t  stb;
  regSel_e     regSel;
  logic [3:0]  idNum;
  logic [31:0] laneMask;
  logic [4:0]  laneShift;
  logic [31:0] wrAligned;
  logic        intStat;

  secmap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busSecure(busSecure),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .lockNow(lockdown), .autoIncNow(autoIncEn),
    .stb(stb), .regSel(regSel), .idNum(idNum),
    .laneMask(laneMask), .laneShift(laneShift), .wrAligned(wrAligned)
  );

  secmap_dp #(.LUT_WORDS(LUT_WORDS), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN),
    .stb(stb), .regSel(regSel), .idNum(idNum),
    .laneMask(laneMask), .laneShift(laneShift), .wrAligned(wrAligned),
    .faultWe(faultWe), .faultAddr(faultAddr), .faultMaster(faultMaster),
    .faultNonSec(faultNonSec), .faultCfgNs(faultCfgNs),
    .lutRdIdx(lutRdIdx),
    .rdData(busRdata), .lutRdWord(lutRdWord),
    .errResp(errRespEn), .autoInc(autoIncEn), .lock(lockdown),
    .intEn(irqEn), .intStat(intStat)
  );

  assign irqOut = intStat & irqEn;

  // R3: a non-secure write below the identification area leaves control state alone
  assert_ns_write_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !busSecure && busAddr < OFS_IDLO)
      |=> $stable({errRespEn, autoIncEn, lockdown, irqEn}));

endmodule

// File: tb/test_secmap_cfg.sv
module test_secmap_cfg;

  localparam int LUT_WORDS   = 4;
  localparam int BLOCK_BYTES = 256;
  localparam int IDXW        = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busSecure = 1'b1;
  logic [11:0] busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [IDXW-1:0] lutRdIdx = '0;
  logic [31:0] lutRdWord;
  logic        errRespEn, autoIncEn, lockdown, irqEn, irqOut;
  logic        faultWe = 1'b0;
  logic [31:0] faultAddr = '0;
  logic [15:0] faultMaster = '0;
  logic        faultNonSec = 1'b0, faultCfgNs = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  secmap_cfg #(.LUT_WORDS(LUT_WORDS), .BLOCK_BYTES(BLOCK_BYTES)) i_secmap_cfg (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busSecure(busSecure),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .lutRdIdx(lutRdIdx), .lutRdWord(lutRdWord),
    .errRespEn(errRespEn), .autoIncEn(autoIncEn), .lockdown(lockdown),
    .irqEn(irqEn), .irqOut(irqOut),
    .faultWe(faultWe), .faultAddr(faultAddr), .faultMaster(faultMaster),
    .faultNonSec(faultNonSec), .faultCfgNs(faultCfgNs)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic sec, output logic [31:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busSize = sz; busSecure = sec;
    #8 rd = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0; busSecure = 1'b1;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, a, d, 2'd2, 1'b1, dummy);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] rd);
    access(1'b0, a, 32'h0, 2'd2, 1'b1, rd);
  endtask

  task automatic expect32(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r;
    rd32(a, r);
    check(req, r, exp);
  endtask

  task automatic expectPort(input string req, input int w, input logic [31:0] exp);
    @(negedge clk);
    lutRdIdx = IDXW'(w);
    #2 check(req, lutRdWord, exp);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 + 32'(i);
  endfunction

  task automatic t_reset();
    expect32("R1 ctrl", 12'h000, 32'h0000_0100);
    expect32("R1 enable", 12'h028, 32'h1);
    expect32("R1 pointer", 12'h018, 32'h0);
    expect32("R1 status", 12'h020, 32'h0);
    expect32("R1 faddr", 12'h02C, 32'h0);
    expect32("R1 finfo", 12'h030, 32'h0);
    for (int w = 0; w < LUT_WORDS; w++) expectPort("R1 R12 table", w, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 R2 exported ctrl", {29'b0, errRespEn, autoIncEn, lockdown}, 32'h2);
  endtask

  task automatic t_geometry();
    expect32("R4 word count", 12'h010, 32'(LUT_WORDS - 1));
    expect32("R4 granule", 12'h014, 32'($clog2(BLOCK_BYTES) - 5));
  endtask

  task automatic t_ident();
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [31:0] r;
    for (int k = 0; k < 12; k++) begin
      access(1'b0, 12'hFD0 + 12'(4 * k), 32'h0, 2'd2, 1'b1, r);
      check("R11 id byte secure", r, {24'b0, exp[k]});
      access(1'b0, 12'hFD0 + 12'(4 * k), 32'h0, 2'd2, 1'b0, r);
      check("R3 R11 id byte non-secure", r, {24'b0, exp[k]});
    end
  endtask

  task automatic t_ctrlMask();
    wr32(12'h000, 32'h7FFF_FFFF);
    expect32("R2 kept bits", 12'h000, 32'h0000_0110);
    check("R2 exported", {29'b0, errRespEn, autoIncEn, lockdown}, 32'h6);
    wr32(12'h000, 32'h0);
    expect32("R2 cleared", 12'h000, 32'h0);
  endtask

  task automatic t_narrow();
    logic [31:0] r;
    access(1'b1, 12'h000, 32'h0000_0110, 2'd1, 1'b1, r);
    expect32("R8 half write ctrl", 12'h000, 32'h0000_0110);
    access(1'b0, 12'h001, 32'h0, 2'd0, 1'b1, r);
    check("R8 byte read lane1", r, 32'h01);
    access(1'b1, 12'h003, 32'h00, 2'd0, 1'b1, r);
    expect32("R8 byte write merges", 12'h000, 32'h0000_0110);
    wr32(12'h000, 32'h0000_0100);
  endtask

  task automatic t_autoStep();
    logic [31:0] r;
    wr32(12'h018, 32'h0);
    for (int w = 0; w < LUT_WORDS; w++) wr32(12'h01C, pat(w));
    for (int w = 0; w < LUT_WORDS; w++) expectPort("R5 R12 streamed word", w, pat(w));
    expect32("R5 pointer wrapped", 12'h018, 32'h0);
    wr32(12'h01C, 32'hDEAD_0000);
    expectPort("R5 wrap write lands in word0", 0, 32'hDEAD_0000);
    expect32("R5 pointer after wrap", 12'h018, 32'h1);
    access(1'b1, 12'h01D, 32'h55, 2'd0, 1'b1, r);
    expectPort("R8 byte merge into window", 1, 32'hC0DE_5501);
    expect32("R5 byte write no step", 12'h018, 32'h1);
    access(1'b0, 12'h01E, 32'h0, 2'd1, 1'b1, r);
    check("R8 half read window", r, 32'h0000_C0DE);
    expect32("R5 half read no step", 12'h018, 32'h1);
    rd32(12'h01C, r);
    check("R5 word read window", r, 32'hC0DE_5501);
    expect32("R5 word read steps", 12'h018, 32'h2);
    wr32(12'h000, 32'h0);
    rd32(12'h01C, r);
    check("R5 read without auto-step", r, pat(2));
    expect32("R5 pointer held", 12'h018, 32'h2);
  endtask

  task automatic t_ptrMod();
    wr32(12'h018, 32'h7);
    expect32("R6 modulo 7", 12'h018, 32'h3);
    wr32(12'h018, 32'h105);
    expect32("R6 modulo 0x105", 12'h018, 32'h1);
  endtask

  task automatic t_nonSecure();
    logic [31:0] r;
    wr32(12'h000, 32'h0000_0110);
    access(1'b1, 12'h000, 32'h0, 2'd2, 1'b0, r);
    expect32("R3 ns ctrl write dropped", 12'h000, 32'h0000_0110);
    access(1'b0, 12'h000, 32'h0, 2'd2, 1'b0, r);
    check("R3 ns ctrl read zero", r, 32'h0);
    access(1'b1, 12'h018, 32'h2, 2'd2, 1'b0, r);
    expect32("R3 ns pointer write dropped", 12'h018, 32'h1);
    access(1'b1, 12'h034, 32'h1, 2'd2, 1'b0, r);
    expect32("R3 ns set dropped", 12'h020, 32'h0);
    wr32(12'h000, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] r;
    wr32(12'h034, 32'h1);
    expect32("R9 set status", 12'h020, 32'h1);
    check("R9 irq high", {31'b0, irqOut}, 32'h1);
    expect32("R9 set reads zero", 12'h034, 32'h0);
    expect32("R9 clear reads zero", 12'h024, 32'h0);
    wr32(12'h028, 32'h0);
    check("R9 irq masked", {31'b0, irqOut}, 32'h0);
    wr32(12'h028, 32'h1);
    access(1'b1, 12'h029, 32'h01, 2'd0, 1'b1, r);
    expect32("R8 narrow enable zero-fill", 12'h028, 32'h0);
    wr32(12'h028, 32'h1);
    wr32(12'h024, 32'h1);
    expect32("R9 clear status", 12'h020, 32'h0);
    check("R9 irq low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_fault();
    @(negedge clk);
    faultWe = 1'b1; faultAddr = 32'h1234_5678; faultMaster = 16'hBEEF;
    faultNonSec = 1'b1; faultCfgNs = 1'b0;
    @(posedge clk); #1 faultWe = 1'b0;
    expect32("R10 fault addr", 12'h02C, 32'h1234_5678);
    expect32("R10 fault info", 12'h030, 32'h0001_BEEF);
    expect32("R10 status set", 12'h020, 32'h1);
    @(negedge clk);
    faultWe = 1'b1; faultAddr = 32'h0000_0040; faultMaster = 16'h0003;
    faultNonSec = 1'b0; faultCfgNs = 1'b1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 12'h024; busWdata = 32'h1;
    busSize = 2'd2; busSecure = 1'b1;
    @(posedge clk); #1;
    faultWe = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    expect32("R10 capture beats clear", 12'h020, 32'h1);
    expect32("R10 second info", 12'h030, 32'h0002_0003);
    wr32(12'h024, 32'h1);
  endtask

  task automatic t_undefined();
    wr32(12'h004, 32'hFFFF_FFFF);
    wr32(12'h800, 32'hFFFF_FFFF);
    expect32("R13 undefined read", 12'h004, 32'h0);
    expect32("R13 undefined read high", 12'h800, 32'h0);
    expect32("R13 ctrl untouched", 12'h000, 32'h0);
    expect32("R13 enable untouched", 12'h028, 32'h1);
  endtask

  task automatic t_lock();
    wr32(12'h018, 32'h3);
    wr32(12'h000, 32'h8000_0110);
    expect32("R7 lock set", 12'h000, 32'h8000_0110);
    wr32(12'h000, 32'h0);
    expect32("R7 ctrl frozen", 12'h000, 32'h8000_0110);
    wr32(12'h01C, 32'h1111_2222);
    expectPort("R7 window frozen", 3, pat(3));
    expect32("R7 locked write no step", 12'h018, 32'h3);
    wr32(12'h028, 32'h0);
    expect32("R7 enable frozen", 12'h028, 32'h1);
    wr32(12'h018, 32'h1);
    expect32("R7 pointer still writable", 12'h018, 32'h1);
    wr32(12'h034, 32'h1);
    expect32("R7 set still works", 12'h020, 32'h1);
    doReset();
    expect32("R7 R1 reset clears lock", 12'h000, 32'h0000_0100);
    expectPort("R7 R1 table cleared", 3, 32'h0);
  endtask

  initial begin
    doReset();
    t_reset();
    t_geometry();
    t_ident();
    t_ctrlMask();
    t_narrow();
    t_autoStep();
    t_ptrMod();
    t_nonSecure();
    t_irq();
    t_fault();
    t_undefined();
    t_lock();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule